// File: doc/BRIEF.md
# ADC Conversion Handshake Sequencer

This block runs single conversions on an external successive-approximation converter. It reaches the converter through a channel-select line, a start-of-conversion line and an end-of-conversion flag. A one-cycle request carries a channel number and a start-low length. The sequencer latches the channel and holds start-of-conversion low for the programmed number of clocks. It then raises start-of-conversion and follows the two-phase handshake: it waits for the flag to drop and then waits for it to rise again. Only after the rise does it capture the 12-bit conversion word.

The result comes out with a one-cycle valid strobe that carries the channel the word belongs to. A conversion can last anywhere from a few milliseconds to tens of milliseconds. Each of the two waits is therefore guarded by a timeout counter, and its limit is a parameter in system clocks. When a wait overruns, the block raises an error pulse, drops start-of-conversion and goes back to idle. The end-of-conversion flag is asynchronous to the system clock, so it passes through a synchronizer before the controller uses it.

Top module: `adc_handshake_seq`

## Requirements
- R1: A request (`req_valid` high while `busy` is low) latches `req_chan` onto `adc_sel`. `adc_sel` stays unchanged for as long as `busy` is high.
- R2: After a request accepted at edge A, `adc_soc` is low until edge A+L and high from edge A+L on. L is `low_cycles`, and a value of 0 counts as 1.
- R3: The flag passes through a two-flop synchronizer. A drop of `adc_eoc` seen at edge X moves the wait to its rising phase at edge X+2. If the flag rises d cycles after it dropped, the result strobe appears at edge X+2+d.
- R4: On completion `res_valid` is high for exactly one cycle. In that cycle `res_data` holds the `adc_data` word captured at that edge and `res_chan` holds the channel of the request. `adc_soc` is low in the same cycle.
- R5: Each wait phase times out after TIMEOUT_CYCLES clocks in that phase. On timeout `err` pulses for one cycle, `adc_soc` is low, the block returns to idle and no result strobe is given.
- R6: If the flag rises in the last cycle of the rising-phase timeout window, completion wins over timeout.
- R7: Requests that arrive while `busy` is high are ignored. They change neither the channel, the start timing nor the reported channel, and no conversion follows them.
- R8: `busy` goes high in the cycle after acceptance and goes low in the same cycle as the `res_valid` or `err` pulse.
- R9: After reset `busy`, `adc_soc`, `adc_sel`, `res_valid` and `err` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Conversion request, one cycle |
| req_chan | input | 1 | Channel to convert with this request |
| low_cycles | input | LOW_W | Start-low length in clocks (0 counts as 1) |
| adc_sel | output | 1 | Channel-select line to the converter |
| adc_soc | output | 1 | Start-of-conversion line to the converter |
| adc_eoc | input | 1 | End-of-conversion flag from the converter, asynchronous |
| adc_data | input | RES_W | Conversion word from the converter |
| busy | output | 1 | A conversion is in progress |
| res_valid | output | 1 | Result strobe, one cycle |
| res_chan | output | 1 | Channel of the reported result |
| res_data | output | RES_W | Captured conversion word |
| err | output | 1 | Timeout pulse, one cycle |

## Verification
Completion of the rising phase and expiry of its timeout can land on the same clock edge. On that edge the controller has to choose between the strobe and the error. The bench provokes this by sweeping the delay between the flag's drop and its rise across every value from 1 to past the timeout limit, with a small limit. For each delay it predicts from the synchronizer latency whether a strobe or an error is due, and in which cycle. The delay equal to the limit is the tie, and the strobe is expected there.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

  typedef enum logic [1:0] {
    ST_IDLE      = 2'd0,
    ST_SOC_LOW   = 2'd1,
    ST_WAIT_LOW  = 2'd2,
    ST_WAIT_HIGH = 2'd3
  } seq_state_t;

  function automatic logic is_wait(input seq_state_t s);
    return (s == ST_WAIT_LOW) || (s == ST_WAIT_HIGH);
  endfunction

endpackage

// File: rtl/adc_eoc_sync.sv
module adc_eoc_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_in,
  output logic q_out
);

  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain <= {STAGES{RST_VAL}};
    end else begin
      for (int i = STAGES - 1; i > 0; i--) begin
        chain[i] <= chain[i-1];
      end
      chain[0] <= d_in;
    end
  end

  assign q_out = chain[STAGES-1];

  // R3: the output only takes a value the first stage held one cycle earlier
  p_sync_follow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> (q_out == $past(chain[STAGES-2])));

endmodule

// File: rtl/adc_low_timer.sv
module adc_low_timer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         run,
  output logic         last
);

  logic [W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (load) begin
      cnt <= load_val;
    end else if (run && cnt != '0) begin
      cnt <= cnt - W'(1);
    end
  end

  assign last = run && (cnt == W'(1));

  // R2: while the start-low phase runs, the counter never sits at zero
  p_low_nonzero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (cnt != '0));

endmodule

// File: rtl/adc_wait_timer.sv
module adc_wait_timer #(
  parameter int LIMIT = 3_000_000,
  parameter int W     = 22
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic run,
  output logic expire
);

  localparam logic [W-1:0] LAST = W'(LIMIT - 1);

  logic [W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (clear) begin
      cnt <= '0;
    end else if (run && cnt != LAST) begin
      cnt <= cnt + W'(1);
    end
  end

  assign expire = run && (cnt == LAST);

  // R5: the window counter never passes the last cycle of the window
  p_cnt_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= LAST);

endmodule

// File: rtl/adc_handshake_seq.sv
module adc_handshake_seq
  import adc_seq_pkg::*;
#(
  parameter int RES_W          = 12,
  parameter int LOW_W          = 8,
  parameter int TIMEOUT_CYCLES = 3_000_000,
  parameter int SYNC_STAGES    = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic             req_chan,
  input  logic [LOW_W-1:0] low_cycles,
  output logic             adc_sel,
  output logic             adc_soc,
  input  logic             adc_eoc,
  input  logic [RES_W-1:0] adc_data,
  output logic             busy,
  output logic             res_valid,
  output logic             res_chan,
  output logic [RES_W-1:0] res_data,
  output logic             err
);

  localparam int TMR_W = $clog2(TIMEOUT_CYCLES + 1);

  // start-low length: a programmed zero still yields one low cycle
  function automatic logic [LOW_W-1:0] low_len(input logic [LOW_W-1:0] v);
    return (v == '0) ? LOW_W'(1) : v;
  endfunction

  seq_state_t st, st_n;
  logic       eoc_s;
  logic       low_last;
  logic       tmr_expire;

  // named internal events
  logic ev_accept, ev_low_done, ev_saw_low, ev_saw_high, ev_timeout, in_wait;

  adc_eoc_sync #(
    .STAGES (SYNC_STAGES),
    .RST_VAL(1'b1)
  ) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d_in (adc_eoc),
    .q_out(eoc_s)
  );

  adc_low_timer #(
    .W(LOW_W)
  ) u_low (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (ev_accept),
    .load_val(low_len(low_cycles)),
    .run     (st == ST_SOC_LOW),
    .last    (low_last)
  );

  adc_wait_timer #(
    .LIMIT(TIMEOUT_CYCLES),
    .W    (TMR_W)
  ) u_wait (
    .clk   (clk),
    .rst_n (rst_n),
    .clear (!in_wait || ev_saw_low),
    .run   (in_wait),
    .expire(tmr_expire)
  );

  always_comb begin
    in_wait     = is_wait(st);
    ev_accept   = (st == ST_IDLE) && req_valid;
    ev_low_done = (st == ST_SOC_LOW) && low_last;
    ev_saw_low  = (st == ST_WAIT_LOW) && !eoc_s;
    ev_saw_high = (st == ST_WAIT_HIGH) && eoc_s;
    // completion has priority over an expiring window
    ev_timeout  = in_wait && tmr_expire && !ev_saw_low && !ev_saw_high;
  end

  always_comb begin
    st_n = st;
    unique case (st)
      ST_IDLE:      if (ev_accept)   st_n = ST_SOC_LOW;
      ST_SOC_LOW:   if (ev_low_done) st_n = ST_WAIT_LOW;
      ST_WAIT_LOW: begin
        if (ev_saw_low)      st_n = ST_WAIT_HIGH;
        else if (ev_timeout) st_n = ST_IDLE;
      end
      ST_WAIT_HIGH: begin
        if (ev_saw_high)     st_n = ST_IDLE;
        else if (ev_timeout) st_n = ST_IDLE;
      end
      default:               st_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= ST_IDLE;
      adc_sel   <= 1'b0;
      adc_soc   <= 1'b0;
      res_valid <= 1'b0;
      res_chan  <= 1'b0;
      res_data  <= '0;
      err       <= 1'b0;
    end else begin
      st        <= st_n;
      res_valid <= ev_saw_high;
      err       <= ev_timeout;
      if (ev_accept)   adc_sel <= req_chan;
      if (ev_accept)   adc_soc <= 1'b0;
      if (ev_low_done) adc_soc <= 1'b1;
      if (ev_saw_high || ev_timeout) adc_soc <= 1'b0;
      if (ev_saw_high) begin
        res_data <= adc_data;
        res_chan <= adc_sel;
      end
    end
  end

  assign busy = (st != ST_IDLE);

  // R1: channel select does not move during a conversion
  p_sel_stable_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(adc_sel));

  // R2: start rises only out of the start-low phase
  p_soc_after_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(adc_soc) |-> ($past(st) == ST_SOC_LOW));

  // R3: the rising phase is entered only after a low flag was seen
  p_high_after_drop_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_WAIT_HIGH && $past(st) == ST_WAIT_LOW) |-> !$past(eoc_s));

  // R4: the strobe comes with start low and the block idle
  p_strobe_clean_r4: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> (!adc_soc && !busy && !err));

  // R4: the strobe lasts one cycle
  p_strobe_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |=> !res_valid);

  // R5: an error pulse lasts one cycle and leaves start low
  p_err_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> !err);
  p_err_soc_r5: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> (!adc_soc && !busy));

  // R6: a rising flag in the rising phase always yields a strobe
  p_complete_wins_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_WAIT_HIGH && eoc_s) |=> (res_valid && !err));

  // R7: a request during a conversion does not end or restart it
  p_ignore_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_SOC_LOW && req_valid && !low_last) |=> (st == ST_SOC_LOW && !adc_soc));

  // R8: busy only falls together with a strobe or an error
  p_busy_end_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (res_valid || err));

endmodule

// File: tb/adc_handshake_seq_tb.sv
module adc_handshake_seq_tb;

  localparam int CLK_PERIOD = 10;
  localparam int T          = 24;
  localparam int LW         = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0;
  logic          req_chan = 1'b0;
  logic [LW-1:0] low_cycles = '0;
  logic          adc_sel, adc_soc;
  logic          adc_eoc = 1'b1;
  logic [11:0]   adc_data = '0;
  logic          busy, res_valid, res_chan, err;
  logic [11:0]   res_data;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  adc_handshake_seq #(
    .RES_W(12), .LOW_W(LW), .TIMEOUT_CYCLES(T), .SYNC_STAGES(2)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_chan(req_chan),
    .low_cycles(low_cycles), .adc_sel(adc_sel), .adc_soc(adc_soc),
    .adc_eoc(adc_eoc), .adc_data(adc_data), .busy(busy),
    .res_valid(res_valid), .res_chan(res_chan), .res_data(res_data), .err(err)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // full conversion: flag drops when start is seen high, rises d cycles later
  task automatic run_full(input bit ch, input int low, input int d, input logic [11:0] data);
    int cnt; int lexp; int n; int expn;
    lexp = (low == 0) ? 1 : low;
    @(negedge clk);
    req_valid = 1'b1; req_chan = ch; low_cycles = LW'(low);
    cnt = 0;
    while (1'b1) begin
      @(negedge clk);
      cnt++;
      if (cnt == 1) begin
        req_valid = 1'b0;
        chk(busy == 1'b1, "R8 busy after accept", int'(busy), 1);
      end
      if (adc_soc || cnt > lexp + 4) break;
    end
    chk(cnt == lexp + 1, "R2 start-low length", cnt, lexp + 1);
    chk(adc_sel == ch, "R1 channel select", int'(adc_sel), int'(ch));
    adc_eoc = 1'b0; adc_data = data; n = 0;
    while (1'b1) begin
      @(negedge clk);
      n++;
      if (n == d) adc_eoc = 1'b1;
      if (res_valid || err || n > d + T + 8) break;
    end
    expn = 3 + ((d < T) ? d : T);
    chk(n == expn, "R3 handshake latency", n, expn);
    if (d <= T) begin
      chk(res_valid && !err, (d == T) ? "R6 completion at window end" : "R4 strobe",
          int'(res_valid), 1);
      chk(res_data == data, "R4 result word", int'(res_data), int'(data));
      chk(res_chan == ch, "R4 result channel", int'(res_chan), int'(ch));
      chk(!adc_soc && !busy, "R8 idle with strobe", int'(adc_soc) + int'(busy), 0);
    end else begin
      chk(err && !res_valid, "R5 timeout in rising phase", int'(err), 1);
      chk(!adc_soc && !busy, "R5 idle after timeout", int'(adc_soc) + int'(busy), 0);
    end
    @(negedge clk);
    chk(!res_valid && !err, "R4 one-cycle pulses", int'(res_valid) + int'(err), 0);
    adc_eoc = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R9: reset state
    chk(!busy && !adc_soc && !adc_sel && !res_valid && !err, "R9 reset state",
        int'(busy) + int'(adc_soc) + int'(adc_sel) + int'(res_valid) + int'(err), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R2 sweep over every start-low length and both channels
    for (int ch = 0; ch < 2; ch++) begin
      for (int lw = 0; lw < (1 << LW); lw++) begin
        run_full(ch[0], lw, 3, 12'((lw * 97 + ch * 1031 + 5) & 12'hFFF));
      end
    end

    // R3/R5/R6 sweep of the rise delay across the timeout boundary
    for (int d = 1; d <= T + 3; d++) begin
      run_full(d[0], 2, d, 12'((d * 37 + 2048) & 12'hFFF));
    end

    // R5: flag never drops in the falling phase
    begin
      int cnt; int n;
      @(negedge clk);
      req_valid = 1'b1; req_chan = 1'b1; low_cycles = LW'(1);
      cnt = 0;
      while (1'b1) begin
        @(negedge clk); cnt++;
        if (cnt == 1) req_valid = 1'b0;
        if (adc_soc || cnt > 8) break;
      end
      n = 0;
      while (1'b1) begin
        @(negedge clk); n++;
        if (err || res_valid || n > T + 8) break;
      end
      chk(n == T && err, "R5 timeout in falling phase", n, T);
      chk(!adc_soc && !busy && !res_valid, "R5 idle after timeout",
          int'(adc_soc) + int'(busy) + int'(res_valid), 0);
      repeat (3) @(negedge clk);
    end

    // R7: request during start-low phase and during rising phase
    begin
      int cnt; int n;
      @(negedge clk);
      req_valid = 1'b1; req_chan = 1'b0; low_cycles = LW'(8);
      cnt = 0;
      while (1'b1) begin
        @(negedge clk); cnt++;
        if (cnt == 1) req_valid = 1'b0;
        if (cnt == 3) begin req_valid = 1'b1; req_chan = 1'b1; low_cycles = LW'(1); end
        if (cnt == 4) req_valid = 1'b0;
        if (adc_soc || cnt > 14) break;
      end
      chk(cnt == 9, "R7 start timing unchanged by request", cnt, 9);
      chk(adc_sel == 1'b0, "R7 channel unchanged by request", int'(adc_sel), 0);
      adc_eoc = 1'b0; adc_data = 12'hA5C; n = 0;
      while (1'b1) begin
        @(negedge clk); n++;
        if (n == 4) begin req_valid = 1'b1; req_chan = 1'b1; end
        if (n == 5) req_valid = 1'b0;
        if (n == 6) adc_eoc = 1'b1;
        if (res_valid || err || n > T + 10) break;
      end
      chk(res_valid && res_chan == 1'b0, "R7 result channel kept", int'(res_chan), 0);
      chk(res_data == 12'hA5C, "R4 result word", int'(res_data), 'hA5C);
      for (int k = 0; k < 6; k++) begin
        @(negedge clk);
        chk(!busy && !adc_soc, "R7 no conversion from ignored request",
            int'(busy) + int'(adc_soc), 0);
      end
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    checks++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule